// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block is a watchdog timer run by a single byte-wide control register. The register packs a two-bit resolution code, a five-bit multiplier and a steering bit. A slow tick input, nominally 16 Hz, decrements a countdown loaded with the programmed interval. When the countdown runs out, the block sets a sticky expiry flag. It then either requests a system reset or emits an interrupt pulse, depending on the steering bit. Software keeps the watchdog from expiring by writing the control register or by reading it. Either access restarts the count.

The block has two byte registers on a small bus. `sel` = 0 addresses the control register and `sel` = 1 addresses the flags register. `rd_data` follows `sel` combinationally at all times. `rd_en` marks a read access, which has side effects. When a reset-steered expiry fires, the block also drives a one-cycle `century_clr` strobe. The neighbouring clock bank uses this strobe to clear its century bit.

The countdown is a three-state machine:
- **IDLE**: no count is running.
- **RUN**: the counter holds the remaining number of ticks.
- **FIRE**: a single-cycle expiry state.

Its transitions are:
- **arm**: IDLE or FIRE to RUN, on a restart with a non-zero interval.
- **disarm**: any state to IDLE, on a restart with a zero interval.
- **decrement**: RUN to RUN, on a tick while more than one tick remains.
- **expire**: RUN to FIRE, on the tick that consumes the last remaining tick.
- **retire**: FIRE to IDLE, when there is no restart.
- **reload**: any state to RUN, on a restart with a non-zero interval.

Top module: `wdt_steer`

## Requirements
- R1: Control register bits [6:2] are the multiplier M and bits [1:0] are the resolution R. The interval is N = M × 4^R ticks. Expiry happens on the N-th clock edge with `tick_16hz` high after the restart edge, and never earlier. The expiry outputs are high during the cycle that follows that edge.
- R2: An interval of zero never expires, however many ticks arrive. This covers a register value of zero and also any value whose multiplier is zero.
- R3: Writing the control register (`wr_en` with `sel` = 0) has three effects. It stores `wr_data`, it clears the expiry flag and it restarts the countdown from the new interval.
- R4: A read of the control register (`rd_en` with `sel` = 0) has two effects. It clears the expiry flag and restarts the countdown from the stored value. A tick in the restart cycle is not counted.
- R5: Expiry sets bit 7 of the flags register, and the flag holds until the next restart. Bits [6:0] of the flags register always read zero.
- R6: When control bit 7 is 1 at expiry, `rst_req` and `century_clr` are each high for exactly one cycle. `irq_pulse` stays low, and the control register then reads zero.
- R7: When control bit 7 is 0 at expiry, `irq_pulse` is high for exactly one cycle. `rst_req` and `century_clr` stay low, and the control register keeps its value.
- R8: Bus writes to the flags register (`sel` = 1) change nothing.
- R9: After an expiry, further ticks produce no new expiry until the control register is written or read.
- R10: A restart in the same cycle as the final tick wins. No expiry occurs, and the full interval starts again.
- R11: After reset, both registers read zero and all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_16hz | input | 1 | One-cycle time-base tick |
| sel | input | 1 | Register select: 0 control, 1 flags |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effects only) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| irq_pulse | output | 1 | One-cycle interrupt on interrupt-steered expiry |
| rst_req | output | 1 | One-cycle reset request on reset-steered expiry |
| century_clr | output | 1 | One-cycle century-clear strobe toward the clock bank |

## Verification
The hardest case to reach is the collision between a restart and the very tick that would expire the count. The count also has to be walked to its exact boundary for every multiplier and resolution, including the longest interval of 1984 ticks. The stimulus handles this by holding the tick input high for a computed number of cycles. Each interval therefore costs one cycle per tick. In the collision test, the bench raises the write strobe and the tick together on the last cycle before expiry. Every one of the 124 non-zero codes is swept, and the steering bit alternates with the multiplier's parity.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_RUN  = 2'd1,
        WD_FIRE = 2'd2
    } wd_state_e;

    localparam logic SEL_CTRL  = 1'b0;
    localparam logic SEL_FLAGS = 1'b1;
endpackage

// File: rtl/wdt_interval.sv
// Decodes multiplier and resolution into an interval in ticks.
module wdt_interval #(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2,
    parameter int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1)
) (
    input  logic [MULT_W-1:0] mult,
    input  logic [RES_W-1:0]  res,
    output logic [CNT_W-1:0]  ticks
);
    localparam int NRES = 1 << RES_W;

    logic [CNT_W-1:0] cand [NRES];

    for (genvar r = 0; r < NRES; r++) begin : g_scale
        assign cand[r] = {{(CNT_W-MULT_W){1'b0}}, mult} << (2 * r);
    end

    assign ticks = cand[res];
endmodule

// File: rtl/wdt_counter.sv
// Countdown state machine: IDLE / RUN / FIRE.
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] load_val,
    output logic             fire
);
    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             last_tick;

    assign last_tick = tick && (cnt_q == CNT_W'(1));

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            WD_IDLE: begin
                if (restart) begin
                    cnt_d   = load_val;
                    state_d = (load_val == '0) ? WD_IDLE : WD_RUN;
                end
            end
            WD_RUN: begin
                if (restart) begin
                    cnt_d   = load_val;
                    state_d = (load_val == '0) ? WD_IDLE : WD_RUN;
                end else if (last_tick) begin
                    cnt_d   = '0;
                    state_d = WD_FIRE;
                end else if (tick) begin
                    cnt_d   = cnt_q - CNT_W'(1);
                end
            end
            WD_FIRE: begin
                if (restart) begin
                    cnt_d   = load_val;
                    state_d = (load_val == '0) ? WD_IDLE : WD_RUN;
                end else begin
                    state_d = WD_IDLE;
                end
            end
            default: begin
                state_d = WD_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        fire = (state_q == WD_FIRE);
    end

    // R10: a restart never lets the next state be the expiry state
    assert_restart_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (state_q != WD_FIRE));

    // R2: a restart with zero interval leaves the counter idle
    assert_zero_idles_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && load_val == '0) |=> (state_q == WD_IDLE));

    // R9: expiry lasts one cycle and is not re-entered without a restart
    assert_single_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_FIRE && !restart) |=> (state_q == WD_IDLE));
endmodule

// File: rtl/wdt_regfile.sv
// Control and flags registers with access side effects.
module wdt_regfile
    import wdt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fire,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              restart,
    output logic [DATA_W-1:0] restart_code
);
    logic flag_q;
    logic wr_ctrl, rd_ctrl;
    logic steer_rst;

    assign wr_ctrl      = wr_en && (sel == SEL_CTRL);
    assign rd_ctrl      = rd_en && !wr_en && (sel == SEL_CTRL);
    assign restart      = wr_ctrl || rd_ctrl;
    assign restart_code = wr_ctrl ? wr_data : ctrl_q;
    assign steer_rst    = ctrl_q[DATA_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= wr_data;
        end else if (fire && steer_rst && !rd_ctrl) begin
            ctrl_q <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (restart) begin
            flag_q <= 1'b0;
        end else if (fire) begin
            flag_q <= 1'b1;
        end
    end

    assign rd_data = (sel == SEL_CTRL) ? ctrl_q : {flag_q, {(DATA_W-1){1'b0}}};

    // R3: a control write stores the data and clears the flag
    assert_write_stores_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (ctrl_q == $past(wr_data)) && !flag_q);

    // R5: expiry without restart leaves the flag set
    assert_flag_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !restart) |=> flag_q);

    // R6: reset-steered expiry clears the control register
    assert_steer_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && steer_rst && !restart) |=> (ctrl_q == '0));

    // R8: flags-register writes do not move the flag
    assert_flags_ro_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_FLAGS && !fire) |=> $stable(flag_q));
endmodule

// File: rtl/wdt_steer.sv
// Top: steerable watchdog timer.
module wdt_steer #(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick_16hz,
    input  logic                      sel,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [MULT_W+RES_W:0]     wr_data,
    output logic [MULT_W+RES_W:0]     rd_data,
    output logic                      irq_pulse,
    output logic                      rst_req,
    output logic                      century_clr
);
    localparam int DATA_W = MULT_W + RES_W + 1;
    localparam int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1);

    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] restart_code;
    logic              restart;
    logic              fire;
    logic [CNT_W-1:0]  load_val;

    wdt_regfile #(.DATA_W(DATA_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel          (sel),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .wr_data      (wr_data),
        .fire         (fire),
        .ctrl_q       (ctrl_q),
        .rd_data      (rd_data),
        .restart      (restart),
        .restart_code (restart_code)
    );

    wdt_interval #(.MULT_W(MULT_W), .RES_W(RES_W), .CNT_W(CNT_W)) u_interval (
        .mult  (restart_code[DATA_W-2:RES_W]),
        .res   (restart_code[RES_W-1:0]),
        .ticks (load_val)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_16hz),
        .restart  (restart),
        .load_val (load_val),
        .fire     (fire)
    );

    assign rst_req     = fire &&  ctrl_q[DATA_W-1];
    assign irq_pulse   = fire && !ctrl_q[DATA_W-1];
    assign century_clr = rst_req;

    // R6 / R7: the two expiry outputs are mutually exclusive
    assert_steer_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && irq_pulse));

    // R6: reset request is a single-cycle pulse
    assert_rst_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
endmodule

// File: tb/test_wdt_steer.sv
module test_wdt_steer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_16hz = 1'b0;
    logic       sel = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq_pulse, rst_req, century_clr;

    int n_checks = 0;
    int n_fail = 0;
    int n_irq = 0;
    int n_rst = 0;
    int n_cen = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdt_steer i_wdt_steer (
        .clk(clk), .rst_n(rst_n), .tick_16hz(tick_16hz), .sel(sel),
        .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
        .irq_pulse(irq_pulse), .rst_req(rst_req), .century_clr(century_clr)
    );

    always @(posedge clk) begin
        if (irq_pulse)   n_irq <= n_irq + 1;
        if (rst_req)     n_rst <= n_rst + 1;
        if (century_clr) n_cen <= n_cen + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        @(negedge clk);
        n_irq = 0; n_rst = 0; n_cen = 0;
    endtask

    task automatic write_reg(input logic s, input logic [7:0] d);
        sel = s; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_ctrl();
        sel = 1'b0; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            tick_16hz = 1'b1;
            repeat (n) @(negedge clk);
            tick_16hz = 1'b0;
        end
    endtask

    task automatic peek(input logic s, output logic [7:0] v);
        sel = s; #1; v = rd_data;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        peek(1'b0, v); check(v == 8'h00, "R11 ctrl", v, 0);
        peek(1'b1, v); check(v == 8'h00, "R11 flags", v, 0);
        check(!irq_pulse && !rst_req && !century_clr, "R11 outputs", {irq_pulse, rst_req, century_clr}, 0);

        // R8: write to flags while clear
        write_reg(1'b1, 8'hFF);
        peek(1'b1, v); check(v == 8'h00, "R8 flags write ignored", v, 0);

        // R1, R5, R6, R7, R9 sweep over all non-zero codes
        for (int r = 0; r < 4; r++) begin
            for (int m = 1; m < 32; m++) begin
                int n;
                bit st;
                logic [7:0] code;
                n = m * (1 << (2 * r));
                st = m[0];
                code = {st, m[4:0], r[1:0]};
                clear_counts();
                write_reg(1'b0, code);
                peek(1'b1, v); check(v == 8'h00, "R3 flag cleared by write", v, 0);
                ticks(n - 1);
                check(n_irq + n_rst == 0, "R1 no early expiry", n_irq + n_rst, 0);
                ticks(1);
                if (st) begin
                    check(rst_req && century_clr && !irq_pulse, "R6 reset steer outputs",
                          {irq_pulse, rst_req, century_clr}, 3);
                end else begin
                    check(irq_pulse && !rst_req && !century_clr, "R7 irq steer outputs",
                          {irq_pulse, rst_req, century_clr}, 4);
                end
                @(negedge clk);
                check(!irq_pulse && !rst_req && !century_clr, "R1 single-cycle expiry",
                      {irq_pulse, rst_req, century_clr}, 0);
                peek(1'b1, v); check(v == 8'h80, "R5 flag set", v, 8'h80);
                peek(1'b0, v);
                if (st) check(v == 8'h00, "R6 ctrl cleared", v, 0);
                else    check(v == code, "R7 ctrl kept", v, code);
                ticks(3);
                if (st) check(n_rst == 1 && n_cen == 1 && n_irq == 0, "R6 pulse count", n_rst, 1);
                else    check(n_irq == 1 && n_rst == 0, "R9 no re-expiry", n_irq, 1);
            end
        end

        // R8: write to flags while set
        write_reg(1'b1, 8'h00);
        peek(1'b1, v); check(v == 8'h80, "R8 flag stays set", v, 8'h80);

        // R2: zero value and zero multiplier never expire
        clear_counts();
        write_reg(1'b0, 8'h00);
        ticks(2500);
        check(n_irq + n_rst == 0, "R2 zero value disabled", n_irq + n_rst, 0);
        write_reg(1'b0, 8'h83);
        ticks(2500);
        check(n_irq + n_rst == 0, "R2 zero multiplier disabled", n_irq + n_rst, 0);

        // R4: read restarts from stored value
        clear_counts();
        write_reg(1'b0, 8'h14);
        ticks(3);
        tick_16hz = 1'b1;
        read_ctrl();
        tick_16hz = 1'b0;
        ticks(4);
        check(n_irq == 0, "R4 read restarted count", n_irq, 0);
        ticks(1);
        check(irq_pulse == 1'b1, "R4 expiry five ticks after read", irq_pulse, 1);
        @(negedge clk);
        peek(1'b1, v); check(v == 8'h80, "R5 flag after read restart", v, 8'h80);
        read_ctrl();
        peek(1'b1, v); check(v == 8'h00, "R4 read clears flag", v, 0);

        // R3: write clears flag and restarts
        ticks(5);
        @(negedge clk);
        peek(1'b1, v); check(v == 8'h80, "R3 setup flag set", v, 8'h80);
        write_reg(1'b0, 8'h08);
        peek(1'b1, v); check(v == 8'h00, "R3 write clears flag", v, 0);
        peek(1'b0, v); check(v == 8'h08, "R3 write stores", v, 8'h08);

        // R10: restart on the final tick wins
        clear_counts();
        ticks(1);
        sel = 1'b0; wr_data = 8'h08; wr_en = 1'b1; tick_16hz = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_16hz = 1'b0;
        @(negedge clk);
        check(n_irq == 0, "R10 restart beats expiry", n_irq, 0);
        ticks(1);
        check(n_irq == 0 && !irq_pulse, "R10 full interval again", n_irq, 0);
        ticks(1);
        check(irq_pulse == 1'b1, "R10 expiry after reload", irq_pulse, 1);
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule